// File: doc/BRIEF.md
# Strobe-Edge Cycle Function Decoder

This block turns the asynchronous, active-low strobe pins of a multiport DRAM port into clean, single-cycle commands for an array model that runs on a system clock. Six pins are brought into the clock domain: the row strobe, the lower and upper column strobes, write enable, transfer enable and a function-select input. Falling and rising edges are then found by comparing each synchronized level with its value one clock earlier.

A falling row strobe latches the cycle class from the other pin levels. The class is a special function, a masked write, a plain read/write, or no RAM access at all. Every later column-strobe fall in a RAM cycle issues one command pulse. The pulse carries a kind code (read, early write, late write or block write) and a two-bit lane mask. A write-enable fall after a read command turns the access into a late write on the same lanes.

The block also produces the data-output enable. It rises with a read command and stays asserted after the column strobes return high, for as long as the row strobe is low. This is the extended-data-out hold.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, cmd_valid_o is 0, cyc_class_o is 0 (no access) and dq_oe_o is 0.
- R2: If fsel_i is high when the row strobe falls, cyc_class_o becomes 3 (special function) and no column command is issued in that row cycle.
- R3: If fsel_i is low at the row-strobe fall, transfer enable and both column strobes are high, then cyc_class_o becomes 2 (masked) with write enable low, or 1 (plain) with write enable high. If transfer enable or a column strobe is low, cyc_class_o becomes 0.
- R4: A column-strobe fall in a class 1 or 2 cycle with fsel_i high issues cmd_kind_o = 3 (block write).
- R5: A column-strobe fall with fsel_i low and write enable low issues cmd_kind_o = 1 (early write), and dq_oe_o is 0.
- R6: A column-strobe fall with fsel_i low and write enable high issues cmd_kind_o = 0 (read), and dq_oe_o becomes 1.
- R7: A write-enable fall after a read command, in the same row cycle, issues cmd_kind_o = 2 (late write) with the lanes of that read. dq_oe_o is unchanged.
- R8: lane_en_o bit 0 is the lower strobe and bit 1 is the upper strobe. It holds exactly the strobes that fell in that clock. Each column or late write-enable edge gives exactly one one-cycle cmd_valid_o pulse.
- R9: dq_oe_o stays 1 after the column strobes rise while the row strobe is low. It returns to 0 together with cyc_class_o returning to 0, after the row strobe rises.
- R10: Column-strobe falls while the row strobe is high, or in a class 0 or 3 cycle, issue no command.
- R11: Outputs respond to a pin change at the third rising clock edge after it: two synchronizer stages, then one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low |
| casl_n_i | input | 1 | Lower-byte column strobe, active low |
| casu_n_i | input | 1 | Upper-byte column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| xfer_n_i | input | 1 | Transfer enable, active low |
| fsel_i | input | 1 | Function select |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_kind_o | output | 2 | 0 read, 1 early write, 2 late write, 3 block write |
| lane_en_o | output | 2 | Byte lanes of the command |
| cyc_class_o | output | 2 | 0 none, 1 plain, 2 masked, 3 special |
| dq_oe_o | output | 1 | Data-output drive enable |

## Verification
The assertions rely on the column strobes falling only after the row strobe has fallen. They also rely on each pin being held for at least three clocks, so that the synchronizer never merges two changes. The bench drives every pin change just after a falling clock edge and holds it for three clocks before the next change. Its random row cycles always lower the row strobe before any column strobe, except in the directed cases that test the ignore rules.

// File: rtl/strobe_dec_pkg.sv
// Package: shared codes for the strobe-edge cycle decoder.
// Assumes: consumers cast two-bit port values to these enums.
package strobe_dec_pkg;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_PLAIN   = 2'd1,
        CLS_MASKED  = 2'd2,
        CLS_SPECIAL = 2'd3
    } cyc_class_t;

    typedef enum logic [1:0] {
        CMD_READ     = 2'd0,
        CMD_EARLY_WR = 2'd1,
        CMD_LATE_WR  = 2'd2,
        CMD_BLOCK_WR = 2'd3
    } cmd_kind_t;

    // Bit positions of the pins in the synchronized vector.
    localparam int PIN_RAS  = 0;
    localparam int PIN_CASL = 1;
    localparam int PIN_CASU = 2;
    localparam int PIN_WE   = 3;
    localparam int PIN_XFER = 4;
    localparam int PIN_FSEL = 5;
    localparam int PIN_COUNT = 6;

endpackage

// File: rtl/strobe_sync_edge.sv
// Module: multi-stage synchronizer with per-bit edge detection.
// Assumes: pins are held long enough that no two changes share one sample.
// All stages reset to 1, which is the inactive level of the strobes.
module strobe_sync_edge #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= pins_i;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= chain_q[LAST];
    end

    assign level_o = chain_q[LAST];

    // Per-bit edge detectors.
    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign fall_o[b] =  prev_q[b] & ~chain_q[LAST][b];
        assign rise_o[b] = ~prev_q[b] &  chain_q[LAST][b];
    end

endmodule

// File: rtl/row_classifier.sv
// Module: latches the cycle class at the row-strobe falling edge.
// Assumes: level inputs are synchronized, active-low strobes; a row rise
// returns the class to "no access".
module row_classifier
    import strobe_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_fall_i,
    input  logic       ras_rise_i,
    input  logic       fsel_i,
    input  logic       we_n_i,
    input  logic       xfer_n_i,
    input  logic       casl_n_i,
    input  logic       casu_n_i,
    output cyc_class_t class_o
);
    cyc_class_t class_q;
    cyc_class_t class_d;

    // Decode the class from the pin levels seen at the row fall.
    always_comb begin
        if (fsel_i)                                class_d = CLS_SPECIAL;
        else if (!xfer_n_i || !casl_n_i || !casu_n_i) class_d = CLS_NONE;
        else if (!we_n_i)                          class_d = CLS_MASKED;
        else                                       class_d = CLS_PLAIN;
    end

    // Hold the class for the whole row cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          class_q <= CLS_NONE;
        else if (ras_rise_i) class_q <= CLS_NONE;
        else if (ras_fall_i) class_q <= class_d;
    end

    assign class_o = class_q;

endmodule

// File: rtl/col_cmd_unit.sv
// Module: issues column commands, late writes and the output drive enable.
// Assumes: the class input is already latched for the current row cycle.
module col_cmd_unit
    import strobe_dec_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_low_i,
    input  logic             ras_rise_i,
    input  cyc_class_t       class_i,
    input  logic [LANES-1:0] col_fall_i,
    input  logic             we_fall_i,
    input  logic             we_n_i,
    input  logic             fsel_i,
    output logic             cmd_valid_o,
    output cmd_kind_t        cmd_kind_o,
    output logic [LANES-1:0] lane_en_o,
    output logic             drive_o
);
    logic             access_ok;
    logic             col_evt;
    logic             late_evt;
    cmd_kind_t        col_kind;
    logic             late_pend_q;
    logic [LANES-1:0] late_lanes_q;
    logic             valid_q;
    cmd_kind_t        kind_q;
    logic [LANES-1:0] lanes_q;
    logic             drive_q;

    // Qualify strobe edges by row state and cycle class.
    assign access_ok = row_low_i && (class_i == CLS_PLAIN || class_i == CLS_MASKED);
    assign col_evt   = access_ok && (|col_fall_i);
    assign late_evt  = access_ok && !col_evt && late_pend_q && we_fall_i;

    // Pick the command kind for a column fall.
    always_comb begin
        if (fsel_i)       col_kind = CMD_BLOCK_WR;
        else if (!we_n_i) col_kind = CMD_EARLY_WR;
        else              col_kind = CMD_READ;
    end

    // Register one command per qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= CMD_READ;
            lanes_q <= '0;
        end else if (col_evt) begin
            valid_q <= 1'b1;
            kind_q  <= col_kind;
            lanes_q <= col_fall_i;
        end else if (late_evt) begin
            valid_q <= 1'b1;
            kind_q  <= CMD_LATE_WR;
            lanes_q <= late_lanes_q;
        end else begin
            valid_q <= 1'b0;
        end
    end

    // Track a read that may turn into a late write.
    always_ff @(posedge clk) begin
        if (!rst_n || !row_low_i) begin
            late_pend_q  <= 1'b0;
            late_lanes_q <= '0;
        end else if (col_evt) begin
            late_pend_q  <= (col_kind == CMD_READ);
            late_lanes_q <= col_fall_i;
        end else if (late_evt) begin
            late_pend_q  <= 1'b0;
        end
    end

    // Output drive: set by a read, held until the row strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_rise_i)                     drive_q <= 1'b0;
        else if (col_evt && col_kind == CMD_READ)     drive_q <= 1'b1;
        else if (col_evt && col_kind == CMD_EARLY_WR) drive_q <= 1'b0;
    end

    assign cmd_valid_o = valid_q;
    assign cmd_kind_o  = kind_q;
    assign lane_en_o   = lanes_q;
    assign drive_o     = drive_q;

endmodule

// File: rtl/strobe_cycle_decoder.sv
// Module: top of the strobe-edge cycle function decoder.
// Assumes: pins are asynchronous to clk and held for several clocks per change.
module strobe_cycle_decoder
    import strobe_dec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n_i,
    input  logic       casl_n_i,
    input  logic       casu_n_i,
    input  logic       we_n_i,
    input  logic       xfer_n_i,
    input  logic       fsel_i,
    output logic       cmd_valid_o,
    output logic [1:0] cmd_kind_o,
    output logic [1:0] lane_en_o,
    output logic [1:0] cyc_class_o,
    output logic       dq_oe_o
);
    logic [PIN_COUNT-1:0] pins;
    logic [PIN_COUNT-1:0] lvl;
    logic [PIN_COUNT-1:0] fall;
    logic [PIN_COUNT-1:0] rise;
    cyc_class_t           cls;
    cmd_kind_t            kind;

    // Gather the pins into one vector in package order.
    always_comb begin
        pins            = '1;
        pins[PIN_RAS]   = ras_n_i;
        pins[PIN_CASL]  = casl_n_i;
        pins[PIN_CASU]  = casu_n_i;
        pins[PIN_WE]    = we_n_i;
        pins[PIN_XFER]  = xfer_n_i;
        pins[PIN_FSEL]  = fsel_i;
    end

    strobe_sync_edge #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .level_o(lvl),
        .fall_o (fall),
        .rise_o (rise)
    );

    row_classifier u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_fall_i(fall[PIN_RAS]),
        .ras_rise_i(rise[PIN_RAS]),
        .fsel_i    (lvl[PIN_FSEL]),
        .we_n_i    (lvl[PIN_WE]),
        .xfer_n_i  (lvl[PIN_XFER]),
        .casl_n_i  (lvl[PIN_CASL]),
        .casu_n_i  (lvl[PIN_CASU]),
        .class_o   (cls)
    );

    col_cmd_unit #(.LANES(2)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_low_i  (!lvl[PIN_RAS]),
        .ras_rise_i (rise[PIN_RAS]),
        .class_i    (cls),
        .col_fall_i ({fall[PIN_CASU], fall[PIN_CASL]}),
        .we_fall_i  (fall[PIN_WE]),
        .we_n_i     (lvl[PIN_WE]),
        .fsel_i     (lvl[PIN_FSEL]),
        .cmd_valid_o(cmd_valid_o),
        .cmd_kind_o (kind),
        .lane_en_o  (lane_en_o),
        .drive_o    (dq_oe_o)
    );

    assign cmd_kind_o  = kind;
    assign cyc_class_o = cls;

endmodule

// File: rtl/strobe_cycle_decoder_chk.sv
// Module: assertion checker bound to the decoder top.
// Assumes: column strobes fall only after the row strobe has fallen.
module strobe_cycle_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_o,
    input logic [1:0] cmd_kind_o,
    input logic [1:0] lane_en_o,
    input logic [1:0] cyc_class_o,
    input logic       dq_oe_o
);
    // R10
    cmd_in_ram_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cyc_class_o == 2'd1 || cyc_class_o == 2'd2));

    // R8
    cmd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (lane_en_o != 2'b00));

    // R6
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_kind_o == 2'd0) |-> dq_oe_o);

    // R5
    early_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_kind_o == 2'd1) |-> !dq_oe_o);

    // R7
    late_keeps_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_kind_o == 2'd2) |-> dq_oe_o);

    // R9
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class_o == 2'd0) |-> !dq_oe_o);

endmodule

bind strobe_cycle_decoder strobe_cycle_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_o(cmd_valid_o),
    .cmd_kind_o (cmd_kind_o),
    .lane_en_o  (lane_en_o),
    .cyc_class_o(cyc_class_o),
    .dq_oe_o    (dq_oe_o)
);

// File: tb/strobe_cycle_decoder_tb.sv
// Bench: directed corners plus seeded random row cycles, checked against
// expected values computed from the requirements.
module strobe_cycle_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;
    localparam int K_READ = 0, K_EARLY = 1, K_LATE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, casl_n = 1'b1, casu_n = 1'b1;
    logic       we_n = 1'b1, xfer_n = 1'b1, fsel = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_kind, lane_en, cyc_class;
    logic       dq_oe;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_cycle_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n_i(ras_n), .casl_n_i(casl_n),
        .casu_n_i(casu_n), .we_n_i(we_n), .xfer_n_i(xfer_n), .fsel_i(fsel),
        .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .lane_en_o(lane_en),
        .cyc_class_o(cyc_class), .dq_oe_o(dq_oe)
    );

    // Count command pulses once per clock.
    always @(negedge clk) if (rst_n && cmd_valid) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait out the three-edge latency (R11), then settle past the edge.
    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    function automatic int exp_class(bit sf, bit we_lo, bit xfer_lo, bit cas_lo);
        if (sf) return 3;
        if (xfer_lo || cas_lo) return 0;
        return we_lo ? 2 : 1;
    endfunction

    function automatic int exp_kind(bit sf, bit we_lo);
        if (sf) return 3;
        return we_lo ? 1 : 0;
    endfunction

    // One full row cycle with expectations derived from the requirements.
    task automatic row_cycle(input bit sf_r, input bit we_r_lo, input bit xfer_lo,
                             input int kind, input bit [1:0] lanes, input bit sf_c);
        int cls, p0, k;
        bit ok, drv;
        p0 = pulses;
        ras_n = 1'b0; fsel = sf_r; we_n = !we_r_lo; xfer_n = !xfer_lo;
        settle();
        cls = exp_class(sf_r, we_r_lo, xfer_lo, 1'b0);
        chk("R2/R3 class at row fall", cyc_class, cls);
        chk("R8 no pulse at row fall", pulses - p0, 0);
        ok = (cls == 1 || cls == 2);
        xfer_n = 1'b1;
        we_n = (kind == K_EARLY) ? 1'b0 : 1'b1;
        fsel = sf_c; casl_n = !lanes[0]; casu_n = !lanes[1];
        settle();
        k = exp_kind(sf_c, kind == K_EARLY);
        drv = ok && (k == 0);
        if (ok) begin
            chk("R4/R5/R6 cmd valid", cmd_valid, 1);
            chk("R4/R5/R6 cmd kind", cmd_kind, k);
            chk("R8 lanes", lane_en, lanes);
            chk("R8 one pulse", pulses - p0, 1);
        end else begin
            chk("R10 no cmd outside RAM cycle", pulses - p0, 0);
        end
        chk("R5/R6 dq_oe after column", dq_oe, drv);
        casl_n = 1'b1; casu_n = 1'b1; fsel = 1'b0;
        settle();
        chk("R9 EDO hold", dq_oe, drv);
        if (kind == K_LATE) begin
            p0 = pulses;
            we_n = 1'b0;
            settle();
            if (ok && k == 0) begin
                chk("R7 late write valid", cmd_valid, 1);
                chk("R7 late write kind", cmd_kind, 2);
                chk("R7 late write lanes", lane_en, lanes);
                chk("R7 dq_oe unchanged", dq_oe, 1);
            end else begin
                chk("R7 no late write", pulses - p0, 0);
            end
        end
        p0 = pulses;
        ras_n = 1'b1; we_n = 1'b1;
        settle();
        chk("R9 class cleared", cyc_class, 0);
        chk("R9 dq_oe cleared", dq_oe, 0);
        chk("R8 no pulse at row rise", pulses - p0, 0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        int p0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset cmd_valid", cmd_valid, 0);
        chk("R1 reset class", cyc_class, 0);
        chk("R1 reset dq_oe", dq_oe, 0);
        settle();

        // R10: column strobes while row high are ignored.
        p0 = pulses;
        casl_n = 1'b0; casu_n = 1'b0;
        settle();
        chk("R10 cas with row high", pulses - p0, 0);
        casl_n = 1'b1; casu_n = 1'b1;
        settle();

        // R11: class appears exactly at the third edge.
        ras_n = 1'b0;
        repeat (2) @(negedge clk); #1;
        chk("R11 class not yet set", cyc_class, 0);
        @(negedge clk); #1;
        chk("R11 class at third edge", cyc_class, 1);
        // R8: separate lane falls give separate commands; late uses last lanes.
        p0 = pulses;
        casl_n = 1'b0;
        settle();
        chk("R8 lower only", lane_en, 2'b01);
        casu_n = 1'b0;
        settle();
        chk("R8 upper only", lane_en, 2'b10);
        chk("R8 two pulses", pulses - p0, 2);
        we_n = 1'b0;
        settle();
        chk("R7 late lanes follow last column fall", lane_en, 2'b10);
        chk("R7 late kind", cmd_kind, 2);
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1;
        settle();
        chk("R9 dq_oe cleared after row rise", dq_oe, 0);

        // R3: column strobe low at the row fall gives no access.
        casl_n = 1'b0;
        settle();
        ras_n = 1'b0;
        settle();
        chk("R3 cas low at row fall", cyc_class, 0);
        ras_n = 1'b1; casl_n = 1'b1;
        settle();

        // Directed corners through the cycle task.
        row_cycle(1'b1, 1'b0, 1'b0, K_READ, 2'b11, 1'b0);  // R2 special
        row_cycle(1'b0, 1'b1, 1'b0, K_EARLY, 2'b10, 1'b0); // R3 masked, R5
        row_cycle(1'b0, 1'b0, 1'b1, K_READ, 2'b01, 1'b0);  // R3 xfer low
        row_cycle(1'b0, 1'b0, 1'b0, K_LATE, 2'b11, 1'b1);  // R4 block
        row_cycle(1'b0, 1'b0, 1'b0, K_LATE, 2'b01, 1'b0);  // R7

        for (int i = 0; i < 200; i++) begin
            row_cycle(($urandom % 5) == 0, $urandom % 2, ($urandom % 6) == 0,
                      int'($urandom % 3), 2'(1 + $urandom % 3), ($urandom % 5) == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule